// File: doc/BRIEF.md
# Passive FPGA Configuration Sequencer

This block loads a bitstream into a passively configured programmable-logic target. It sits behind a single-cycle register port and works in two address spaces. The control window holds status, control, extra-clock and pin-monitor registers. The data window accepts configuration words.

Software takes ownership of the target's configuration pins. It pulses the target's configuration reset and waits for the phase code to reach the configuration phase. It then opens the data window and streams words. Each accepted word is presented on the parallel data pins and clocked in with a number of configuration-clock pulses set by the clock-to-data ratio. Once the target reports done, software requests a programmable burst of extra clock pulses to walk the target through initialization into user mode. A done flag marks the end of each burst.

The phase code is derived from the target's handshake pins. The ratio and width that suit the board are decoded from a five-bit strap input.

Top module: `cfg_sequencer`

## Requirements
- R1: After reset the control register reads 0, the phase code (status bits 2:0) reads 0, the burst-done flag reads 0 and every pin output enable is low.
- R2: With ownership (control bit0) set and the reset pull (control bit2) clear, the phase code is chosen in this order:
  - 1 (reset) while the target status pin is low.
  - Otherwise 2 (configuration) while done and init-done are low.
  - Otherwise 3 (initialization) with done high and init-done low.
  - Otherwise 4 (user) with both high.
  - Otherwise 5 (unknown) with init-done high and done low.
  - Without ownership the phase code is 0.
- R3: Status bits 7:3 mirror the strap input. Status bits 9:8 give a ratio code decoded from strap[3:0] masked with 0xB:
  - 0xA gives 3 (×8).
  - 0x2 or 0x9 gives 2 (×4).
  - 0x1 gives 1 (×2).
  - Any other value gives 0 (×1).
  - Status bit10 equals strap bit3 (wide path).
- R4: Setting control bit2 with ownership drives the configuration-reset pin low and forces phase 1. After bit2 is cleared the phase stays 1 until the target status pin goes high, then becomes 2.
- R5: A word written to the data window is discarded, with no clock pulse and no change on the data pins, unless ownership, control bit8 and phase 2 all hold.
- R6: An accepted word appears on the data pins and is followed by exactly 2^(control bits 7:6) clock pulses. With control bit9 clear, only the low 16 bits are driven and the upper bits are zero.
- R7: Writing N to the extra-clock register (0x8) with ownership produces exactly N clock pulses. Register 0xC bit0 then reads 1 until 1 is written to it.
- R8: Writing the extra-clock register while a burst runs replaces the remaining count. Exactly the new N pulses follow, and the done flag stays 0 until that count reaches zero.
- R9: While control bit0 is clear, all pin output enables are low, no clock pulse is produced, and writes to the extra-clock register are ignored (it reads 0).
- R10: Register 0x850 returns the live target pins: status in bit0, done in bit1, init-done in bit2, CRC error in bit3.
- R11: Register 0x84C latches a change on any of those four pins in the same bit position. Writing a mask there clears the masked bits.
- R12: With ownership and no reset pull, status bit11 reads 1 when the status and done pins are both low (error). Status bit12 reads 1 when both are high (complete).
- R13: Every clock pulse is high for exactly one cycle and is followed by at least one low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_win | input | 1 | 0 selects the control window, 1 the data window |
| bus_addr | input | 12 | Byte offset within the control window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr and bus_win |
| strap_i | input | 5 | Board mode-select straps |
| tgt_stat_n_i | input | 1 | Target status, low while in reset or on error |
| tgt_done_i | input | 1 | Target configuration done |
| tgt_init_i | input | 1 | Target initialization done |
| tgt_crc_i | input | 1 | Target CRC error |
| tgt_rst_n_o | output | 1 | Target configuration reset, active low |
| tgt_rst_oe_o | output | 1 | Output enable for tgt_rst_n_o |
| tgt_ce_n_o | output | 1 | Target chip enable, active low |
| tclk_o | output | 1 | Configuration clock |
| tclk_oe_o | output | 1 | Output enable for tclk_o |
| tdata_o | output | 32 | Parallel configuration data |
| tdata_oe_o | output | 1 | Output enable for tdata_o |

## Verification
On every cycle the assertions check four things:
- Each clock pulse lasts exactly one cycle.
- Releasing ownership stops all pulse activity on the next cycle.
- The done flag can rise only with an empty count.
- A word burst can start only when the window was open in the configuration phase.

Some behaviour can only be shown by the directed scenarios:
- Exact pulse counts per word and per burst.
- Replacement of a running count.
- The strap decode table.
- The phase ordering against the target pins.
- The pin-change latch and its clear.

// File: rtl/cfg_sequencer.sv
module cfg_sequencer #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_win,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [4:0]        strap_i,
  input  logic              tgt_stat_n_i,
  input  logic              tgt_done_i,
  input  logic              tgt_init_i,
  input  logic              tgt_crc_i,
  output logic              tgt_rst_n_o,
  output logic              tgt_rst_oe_o,
  output logic              tgt_ce_n_o,
  output logic              tclk_o,
  output logic              tclk_oe_o,
  output logic [DATA_W-1:0] tdata_o,
  output logic              tdata_oe_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] A_XCNT = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] A_XDON = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(12'h84C);
  localparam logic [ADDR_W-1:0] A_PINS = ADDR_W'(12'h850);
  localparam int HALF_W = DATA_W / 2;

  logic [9:0]        ctrl;
  logic [CNT_W-1:0]  xcnt;
  logic [3:0]        wcnt;
  logic              clk_hi, done;
  logic [DATA_W-1:0] data_r;
  logic [3:0]        pin_q, evt;
  logic [2:0]        phase;
  logic [1:0]        dec_ratio;
  logic              own, err_f, cmp_f;

  wire [3:0] pins   = {tgt_crc_i, tgt_init_i, tgt_done_i, tgt_stat_n_i};
  wire       csr_wr = bus_en && bus_we && !bus_win;
  wire       cnt_wr = csr_wr && bus_addr == A_XCNT && own;
  wire       word_wr = bus_en && bus_we && bus_win && own && ctrl[8]
                       && phase == 3'd2 && wcnt == 4'd0;

  assign own = ctrl[0];

  always_comb begin
    if (!own)                        phase = 3'd0;
    else if (ctrl[2] || !tgt_stat_n_i) phase = 3'd1;
    else if (!tgt_done_i)            phase = tgt_init_i ? 3'd5 : 3'd2;
    else                             phase = tgt_init_i ? 3'd4 : 3'd3;
  end

  always_comb begin
    case (strap_i[3:0] & 4'hB)
      4'hA:        dec_ratio = 2'd3;
      4'h2, 4'h9:  dec_ratio = 2'd2;
      4'h1:        dec_ratio = 2'd1;
      default:     dec_ratio = 2'd0;
    endcase
  end

  assign err_f = own && !ctrl[2] && !tgt_stat_n_i && !tgt_done_i;
  assign cmp_f = own && tgt_stat_n_i && tgt_done_i;

  always_comb begin
    bus_rdata = '0;
    if (!bus_win) begin
      case (bus_addr)
        A_STAT: bus_rdata = DATA_W'({cmp_f, err_f, strap_i[3], dec_ratio, strap_i, phase});
        A_CTRL: bus_rdata = DATA_W'(ctrl);
        A_XCNT: bus_rdata = DATA_W'(xcnt);
        A_XDON: bus_rdata = DATA_W'(done);
        A_EVT:  bus_rdata = DATA_W'(evt);
        A_PINS: bus_rdata = DATA_W'(pins);
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; xcnt <= '0; wcnt <= '0; clk_hi <= 1'b0; done <= 1'b0;
      data_r <= '0; pin_q <= '0; evt <= '0;
    end else begin
      pin_q <= pins;
      evt   <= (evt & ~((csr_wr && bus_addr == A_EVT) ? bus_wdata[3:0] : 4'd0)) | (pins ^ pin_q);
      if (csr_wr && bus_addr == A_CTRL) ctrl <= bus_wdata[9:0];
      if (csr_wr && bus_addr == A_XDON && bus_wdata[0]) done <= 1'b0;
      if (!own) begin
        xcnt <= '0; wcnt <= '0; clk_hi <= 1'b0;
      end else begin
        if (clk_hi) clk_hi <= 1'b0;
        else if (!cnt_wr) begin
          if (wcnt != 4'd0) begin
            clk_hi <= 1'b1; wcnt <= wcnt - 4'd1;
          end else if (xcnt != '0) begin
            clk_hi <= 1'b1; xcnt <= xcnt - 1'b1;
            if (xcnt == CNT_W'(1)) done <= 1'b1;
          end
        end
        if (cnt_wr) xcnt <= bus_wdata[CNT_W-1:0];
        if (word_wr) begin
          wcnt   <= 4'd1 << ctrl[7:6];
          data_r <= ctrl[9] ? bus_wdata : {{(DATA_W-HALF_W){1'b0}}, bus_wdata[HALF_W-1:0]};
        end
      end
    end
  end

  assign tgt_rst_n_o  = ~ctrl[2];
  assign tgt_rst_oe_o = own;
  assign tgt_ce_n_o   = ctrl[1];
  assign tclk_o       = clk_hi;
  assign tclk_oe_o    = own;
  assign tdata_o      = data_r;
  assign tdata_oe_o   = own;

  // R13
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n) clk_hi |=> !clk_hi);
  // R9
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !own |=> (xcnt == '0 && wcnt == 4'd0 && !tclk_o));
  // R8
  done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> xcnt == '0);
  // R5
  window_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcnt != 4'd0) |-> $past(phase == 3'd2 && ctrl[8]));
  // R6
  word_count_chk: assert property (@(posedge clk) disable iff (!rst_n) wcnt <= 4'd8);
endmodule

// File: tb/tb_cfg_sequencer.sv
`timescale 1ns/100ps
module tb_cfg_sequencer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 0, bus_we = 0, bus_win = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [4:0] strap = '0;
  logic s_n = 0, cd = 0, id = 0, crc = 0;
  logic rst_o, rst_oe, ce_n, tclk, tclk_oe, d_oe;
  logic [31:0] tdata;
  int checks = 0, errors = 0, rises = 0;
  logic dprev = 0;

  always #2.5 clk = ~clk;

  cfg_sequencer dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_win(bus_win),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strap_i(strap),
    .tgt_stat_n_i(s_n), .tgt_done_i(cd), .tgt_init_i(id), .tgt_crc_i(crc),
    .tgt_rst_n_o(rst_o), .tgt_rst_oe_o(rst_oe), .tgt_ce_n_o(ce_n), .tclk_o(tclk),
    .tclk_oe_o(tclk_oe), .tdata_o(tdata), .tdata_oe_o(d_oe));

  always @(negedge clk) begin
    if (tclk && !dprev) rises++;
    dprev = tclk;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic win, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_win = win; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0; bus_win = 0;
    #1;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_win = 0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pins(logic a, logic b, logic c);
    @(negedge clk);
    s_n = a; cd = b; id = c;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(12'h004, v); chk("R1 ctrl", v, 0);
    rd(12'h000, v); chk("R1 phase", v[2:0], 0);
    rd(12'h00C, v); chk("R1 done", v, 0);
    chk("R1 oe", {rst_oe, tclk_oe, d_oe}, 0);
  endtask

  task automatic t_strap;
    logic [31:0] v;
    logic [1:0] er;
    logic [4:0] vals [8] = '{5'h0A, 5'h02, 5'h09, 5'h01, 5'h0B, 5'h18, 5'h0E, 5'h15};
    for (int i = 0; i < 8; i++) begin
      strap = vals[i];
      case (vals[i][3:0] & 4'hB)
        4'hA: er = 3;
        4'h2, 4'h9: er = 2;
        4'h1: er = 1;
        default: er = 0;
      endcase
      rd(12'h000, v);
      chk("R3 strap", v[7:3], vals[i]);
      chk("R3 ratio", v[9:8], er);
      chk("R3 wide", v[10], vals[i][3]);
    end
  endtask

  task automatic t_phase;
    logic [31:0] v;
    wr(0, 12'h004, 32'h5);
    rd(12'h000, v); chk("R4 pull phase", v[2:0], 1);
    chk("R4 pin low", {rst_o, rst_oe}, 2'b01);
    wr(0, 12'h004, 32'h1);
    rd(12'h000, v); chk("R4 held by target", v[2:0], 1);
    chk("R12 error flag", v[12:11], 2'b01);
    set_pins(1, 0, 0); rd(12'h000, v); chk("R4 config phase", v[2:0], 2);
    set_pins(1, 1, 0); rd(12'h000, v); chk("R2 init phase", v[2:0], 3);
    chk("R12 complete flag", v[12:11], 2'b10);
    set_pins(1, 1, 1); rd(12'h000, v); chk("R2 user phase", v[2:0], 4);
    set_pins(1, 0, 1); rd(12'h000, v); chk("R2 unknown phase", v[2:0], 5);
    wr(0, 12'h004, 32'h0);
    rd(12'h000, v); chk("R2 off phase", v[2:0], 0);
  endtask

  task automatic t_window;
    int b;
    set_pins(1, 0, 0);
    wr(0, 12'h004, 32'h201 | (3 << 6));
    b = rises; wr(1, 0, 32'hDEADBEEF); wait_cyc(20);
    chk("R5 closed window pulses", rises - b, 0);
    chk("R5 closed window data", tdata, 0);
    set_pins(1, 1, 0);
    wr(0, 12'h004, 32'h301 | (3 << 6));
    b = rises; wr(1, 0, 32'hDEADBEEF); wait_cyc(20);
    chk("R5 wrong phase pulses", rises - b, 0);
    set_pins(1, 0, 0);
    for (int r = 0; r < 4; r++) begin
      logic wide = r[0];
      logic [31:0] w = 32'hA5C3_0000 + r;
      wr(0, 12'h004, 32'h101 | (r << 6) | (wide << 9));
      b = rises; wr(1, 0, w); wait_cyc(20);
      chk("R6 pulses per word", rises - b, 1 << r);
      chk("R6 data pins", tdata, wide ? w : {16'h0, w[15:0]});
    end
  endtask

  task automatic t_extra;
    logic [31:0] v;
    int b;
    wr(0, 12'h004, 32'h1);
    b = rises; wr(0, 12'h008, 4); wait_cyc(12);
    chk("R7 four pulses", rises - b, 4);
    rd(12'h00C, v); chk("R7 done", v, 1);
    wr(0, 12'h00C, 1); rd(12'h00C, v); chk("R7 done clear", v, 0);
    b = rises; wr(0, 12'h008, 32'h5000); wait_cyc(2 * 32'h5000 + 4);
    chk("R7 long burst", rises - b, 32'h5000);
    rd(12'h00C, v); chk("R7 long done", v, 1);
    wr(0, 12'h00C, 1);
  endtask

  task automatic t_replace;
    logic [31:0] v;
    int b;
    wr(0, 12'h008, 100); wait_cyc(10);
    rd(12'h00C, v); chk("R8 no early done", v, 0);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_win = 0; bus_addr = 12'h008; bus_wdata = 3;
    #1 b = rises;
    @(negedge clk); bus_en = 0; bus_we = 0;
    #1; rd(12'h00C, v); chk("R8 done held", v, 0);
    wait_cyc(12);
    chk("R8 replaced count pulses", rises - b, 3);
    rd(12'h00C, v); chk("R8 done after replace", v, 1);
    wr(0, 12'h00C, 1);
  endtask

  task automatic t_release;
    logic [31:0] v;
    int b;
    wr(0, 12'h004, 32'h0);
    chk("R9 released oe", {rst_oe, tclk_oe, d_oe}, 0);
    b = rises; wr(0, 12'h008, 5); wait_cyc(14);
    chk("R9 no pulses", rises - b, 0);
    rd(12'h008, v); chk("R9 count ignored", v, 0);
  endtask

  task automatic t_monitor;
    logic [31:0] v;
    @(negedge clk); s_n = 1; cd = 0; id = 1; crc = 0;
    rd(12'h850, v); chk("R10 pins", v, 32'h5);
    wr(0, 12'h84C, 32'hFFF); wait_cyc(2);
    rd(12'h84C, v); chk("R11 cleared", v, 0);
    @(negedge clk); crc = 1; wait_cyc(2);
    rd(12'h84C, v); chk("R11 crc event", v, 32'h8);
    rd(12'h850, v); chk("R10 crc pin", v, 32'hD);
    wr(0, 12'h84C, 32'hFFF); wait_cyc(1);
    rd(12'h84C, v); chk("R11 clear", v, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_strap();
    t_phase();
    t_window();
    t_extra();
    t_replace();
    t_release();
    t_monitor();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule